// File: doc/BRIEF.md
# Block-Parallel QPSK Costas Carrier Recovery

This block tracks and removes the carrier phase of a QPSK sample stream that arrives several complex samples at a time. Each clock may present one block of `N` samples, one per lane, qualified by a single valid flag. Every lane rotates its sample back by a phase taken from a shared numerically controlled oscillator, and then derives a decision-directed QPSK phase error from the rotated result. The lane errors of a block are summed, and the sum drives a proportional-integral update of the oscillator's phase and frequency state.

The oscillator holds a base phase and a frequency word. Within a block, lane `k` uses the base phase plus `k` times the frequency, so the phase ramps across the lanes just as a serial oscillator would ramp from one sample to the next. The error sum reaches the loop state through `FB_STAGES` extra register stages. This reproduces the pipeline depth that a fast, wide build needs for timing, and the feedback latency it costs. Wider blocks and deeper feedback pipelines both lower the loop bandwidth that remains stable, so the gains must be chosen with the total delay in mind.

The derotated block and the current frequency word are the outputs. The lane count may be any positive integer, including values that are not powers of two.

Top module: `costas_par_top`

## Requirements
- R1: While `rst` is high at a clock edge, the next state clears `out_valid`, `out_i`, `out_q`, the base phase and `freq_est` to zero.
- R2: Lane `k` (0-based) uses phase `(PHI + k*F) mod 2^PH_W`, where PHI is the base phase and F is the frequency word. Its table index is the top `LUT_AW` bits of that phase. The sine is `sin[idx]`, and the cosine is `sin[(idx + 2^LUT_AW/4) mod 2^LUT_AW]`. For `H = 2^(LUT_AW-1)`, `u = idx mod H` and `A = 2^(AW-1)-1`, `sin[idx] = floor((A*16u(H-u) + D/2) / D)` with `D = 5H^2 - 4u(H-u)`, negated when `idx >= H`.
- R3: Lane `k` of `in_i`, `in_q`, `out_i` and `out_q` occupies bits `[k*DW +: DW]` as two's complement. The rotated outputs are `yI = R(I*c + Q*s)` and `yQ = R(Q*c - I*s)`. `R(x)` is `floor((x + 2^(AW-2)) / 2^(AW-1))`, saturated to `±(2^(DW-1)-1)`, so the most negative code never appears.
- R4: `out_valid` equals `in_valid` one clock earlier. On a valid edge, `out_i` and `out_q` load the rotated block. Otherwise they hold, and the inputs are ignored.
- R5: The lane error is `sgn(yI)*yQ - sgn(yQ)*yI`, computed on the registered outputs, with `sgn(v) = -1` for `v < 0` and `+1` otherwise. The block error `E` is the sum over all lanes.
- R6: The error of a block captured at edge `t` reaches the loop state at edge `t + 1 + FB_STAGES`. `freq_est` is unchanged at the edges in between.
- R7: At the edge where a block error `E` arrives, F gains `KI*E` and PHI gains `KP*E`. All phase and frequency arithmetic wraps modulo `2^PH_W`.
- R8: At every edge with `in_valid` high, PHI also gains `N*F`, using F from before that edge. Without `in_valid`, PHI gets no advance.
- R9: `freq_est` is the frequency word F, a `PH_W`-bit two's complement value in units of `2^-PH_W` cycles per sample.
- R10: Any positive lane count `N` is supported; the default build uses 5 lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the input block |
| in_i | input | N*DW | In-phase samples, lane k at [k*DW +: DW] |
| in_q | input | N*DW | Quadrature samples, same packing |
| out_valid | output | 1 | Qualifies the derotated block |
| out_i | output | N*DW | Derotated in-phase samples |
| out_q | output | N*DW | Derotated quadrature samples |
| freq_est | output | PH_W | Current frequency word |

## Verification
The bench runs a single isolated block and counts the edges before `freq_est` moves. A pipeline one stage short or long shifts that edge and breaks the stability budget of the loop. Gaps inside a rotating QPSK stream carry garbage data on the inputs. A design that advanced the phase or consumed samples in those gaps would leave every following block wrongly rotated. Full-scale blocks at oblique phases push the rotation into saturation. Asymmetric clamping would emit the most negative code, and missing clamping would wrap sign. A reset in the middle of a run checks that no error still in flight survives into the new run.

// File: rtl/costas_pkg.sv
package costas_pkg;

    // Width of the block error word carried through the feedback pipeline
    localparam int SUM_W = 32;

    // One slot of the feedback pipeline: a block error and its qualifier
    typedef struct packed {
        logic                    vld;
        logic signed [SUM_W-1:0] sum;
    } fb_tok_t;

    // Rational sine approximation over a table of 2^abits entries
    function automatic int sine_code(input int idx, input int abits, input int amp);
        longint half, u, num, den, mag;
        half = longint'(1) <<< (abits - 1);
        u    = longint'(idx) % half;
        num  = 16 * u * (half - u);
        den  = 5 * half * half - 4 * u * (half - u);
        mag  = (longint'(amp) * num + den / 2) / den;
        return (longint'(idx) >= half) ? -int'(mag) : int'(mag);
    endfunction

    // Round a product down by sh bits and clamp it symmetrically to dw bits
    function automatic longint round_sat(input longint acc, input int sh, input int dw);
        longint r, lim;
        r   = (acc + (longint'(1) <<< (sh - 1))) >>> sh;
        lim = (longint'(1) <<< (dw - 1)) - 1;
        if (r > lim)
            r = lim;
        else if (r < -lim)
            r = -lim;
        return r;
    endfunction

endpackage

// File: rtl/costas_derot.sv
module costas_derot
    import costas_pkg::*;
#(
    parameter int DW     = 12,
    parameter int AW     = 12,
    parameter int LUT_AW = 6
)
(
    input  logic        [LUT_AW-1:0] idx,
    input  logic signed [DW-1:0]     x_i,
    input  logic signed [DW-1:0]     x_q,
    output logic signed [DW-1:0]     y_i,
    output logic signed [DW-1:0]     y_q
);
    localparam int                LUT_N = 1 << LUT_AW;
    localparam int                AMP   = (1 << (AW - 1)) - 1;
    localparam int                PW    = DW + AW + 1;
    localparam logic [LUT_AW-1:0] QTR   = LUT_AW'(LUT_N / 4);

    // Sine table, built from the constant function at elaboration
    logic signed [AW-1:0] sin_tab [LUT_N];

    for (genvar g = 0; g < LUT_N; g++) begin : g_tab
        localparam int CODE = sine_code(g, LUT_AW, AMP);
        assign sin_tab[g] = AW'(CODE);
    end

    logic        [LUT_AW-1:0] c_idx;
    logic signed [AW-1:0]     s_val;
    logic signed [AW-1:0]     c_val;
    logic signed [PW-1:0]     acc_i;
    logic signed [PW-1:0]     acc_q;

    // Cosine is the sine a quarter turn later
    assign c_idx = idx + QTR;
    assign s_val = sin_tab[idx];
    assign c_val = sin_tab[c_idx];

    // Multiply by the conjugate phasor: (I + jQ)(c - js)
    assign acc_i = PW'(x_i) * PW'(c_val) + PW'(x_q) * PW'(s_val);
    assign acc_q = PW'(x_q) * PW'(c_val) - PW'(x_i) * PW'(s_val);

    assign y_i = DW'(round_sat(longint'(acc_i), AW - 1, DW));
    assign y_q = DW'(round_sat(longint'(acc_q), AW - 1, DW));

endmodule

// File: rtl/costas_err_sum.sv
module costas_err_sum
    import costas_pkg::*;
#(
    parameter int N  = 5,
    parameter int DW = 12
)
(
    input  logic        [N*DW-1:0]  d_i,
    input  logic        [N*DW-1:0]  d_q,
    output logic signed [SUM_W-1:0] sum
);
    logic signed [SUM_W-1:0] lane_err [N];

    // One memoryless detector per lane
    for (genvar g = 0; g < N; g++) begin : g_det
        logic signed [DW-1:0] xi;
        logic signed [DW-1:0] xq;
        assign xi = d_i[g*DW +: DW];
        assign xq = d_q[g*DW +: DW];
        assign lane_err[g] = (xi[DW-1] ? -SUM_W'(xq) : SUM_W'(xq))
                           - (xq[DW-1] ? -SUM_W'(xi) : SUM_W'(xi));
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < N; k++)
            sum = sum + lane_err[k];
    end

endmodule

// File: rtl/costas_loop_ctl.sv
module costas_loop_ctl
    import costas_pkg::*;
#(
    parameter int N         = 5,
    parameter int PH_W      = 24,
    parameter int FB_STAGES = 3,
    parameter int KP        = 16,
    parameter int KI        = 1
)
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    blk_vld,
    input  logic                    err_vld,
    input  logic signed [SUM_W-1:0] err_sum,
    output logic        [PH_W-1:0]  phase_base,
    output logic        [PH_W-1:0]  freq
);
    fb_tok_t tok_in;
    fb_tok_t tok_out;

    assign tok_in = '{vld: err_vld, sum: err_sum};

    // Extra feedback latency, chosen by parameter
    if (FB_STAGES == 0) begin : g_direct
        assign tok_out = tok_in;
    end else begin : g_pipe
        fb_tok_t pipe_q [FB_STAGES];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int k = 0; k < FB_STAGES; k++)
                    pipe_q[k] <= '0;
            end else begin
                pipe_q[0] <= tok_in;
                for (int k = 1; k < FB_STAGES; k++)
                    pipe_q[k] <= pipe_q[k-1];
            end
        end
        assign tok_out = pipe_q[FB_STAGES-1];
    end

    logic [PH_W-1:0] e_wrap;
    logic [PH_W-1:0] adv;
    logic [PH_W-1:0] corr_p;
    logic [PH_W-1:0] corr_f;

    assign e_wrap = PH_W'(tok_out.sum);

    always_comb begin
        adv    = blk_vld     ? freq * PH_W'(N)    : '0;
        corr_p = tok_out.vld ? e_wrap * PH_W'(KP) : '0;
        corr_f = tok_out.vld ? e_wrap * PH_W'(KI) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_base <= '0;
            freq       <= '0;
        end else begin
            phase_base <= phase_base + adv + corr_p;
            freq       <= freq + corr_f;
        end
    end

endmodule

// File: rtl/costas_par_top.sv
module costas_par_top
    import costas_pkg::*;
#(
    parameter int N         = 5,
    parameter int DW        = 12,
    parameter int AW        = 12,
    parameter int LUT_AW    = 6,
    parameter int PH_W      = 24,
    parameter int FB_STAGES = 3,
    parameter int KP        = 16,
    parameter int KI        = 1
)
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [N*DW-1:0]      in_i,
    input  logic [N*DW-1:0]      in_q,
    output logic                 out_valid,
    output logic [N*DW-1:0]      out_i,
    output logic [N*DW-1:0]      out_q,
    output logic [PH_W-1:0]      freq_est
);
    logic        [PH_W-1:0]  phase_base;
    logic        [N*DW-1:0]  rot_i;
    logic        [N*DW-1:0]  rot_q;
    logic signed [SUM_W-1:0] blk_err;

    // Per-lane phase ramp and derotation
    for (genvar g = 0; g < N; g++) begin : g_lane
        logic        [LUT_AW-1:0] idx;
        logic signed [DW-1:0]     yi;
        logic signed [DW-1:0]     yq;

        assign idx = LUT_AW'((phase_base + freq_est * PH_W'(g)) >> (PH_W - LUT_AW));

        costas_derot #(
            .DW     (DW),
            .AW     (AW),
            .LUT_AW (LUT_AW)
        ) u_rot (
            .idx (idx),
            .x_i (in_i[g*DW +: DW]),
            .x_q (in_q[g*DW +: DW]),
            .y_i (yi),
            .y_q (yq)
        );

        assign rot_i[g*DW +: DW] = yi;
        assign rot_q[g*DW +: DW] = yq;
    end

    // Output register; holds through gaps
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_i <= rot_i;
                out_q <= rot_q;
            end
        end
    end

    costas_err_sum #(
        .N  (N),
        .DW (DW)
    ) u_err (
        .d_i (out_i),
        .d_q (out_q),
        .sum (blk_err)
    );

    costas_loop_ctl #(
        .N         (N),
        .PH_W      (PH_W),
        .FB_STAGES (FB_STAGES),
        .KP        (KP),
        .KI        (KI)
    ) u_loop (
        .clk        (clk),
        .rst        (rst),
        .blk_vld    (in_valid),
        .err_vld    (out_valid),
        .err_sum    (blk_err),
        .phase_base (phase_base),
        .freq       (freq_est)
    );

endmodule

// File: rtl/costas_par_chk.sv
module costas_par_chk #(
    parameter int N         = 5,
    parameter int DW        = 12,
    parameter int PH_W      = 24,
    parameter int FB_STAGES = 3
)
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            out_valid,
    input  logic [N*DW-1:0] out_i,
    input  logic [N*DW-1:0] out_q,
    input  logic [PH_W-1:0] freq_est
);
    localparam logic [DW-1:0] MIN_CODE = {1'b1, {(DW-1){1'b0}}};

    // Edges since out_valid was last seen high, saturating
    int quiet;
    always_ff @(posedge clk) begin
        if (rst)
            quiet <= FB_STAGES + 1;
        else if (out_valid)
            quiet <= 0;
        else if (quiet <= FB_STAGES)
            quiet <= quiet + 1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (freq_est == '0 && !out_valid));

    // R4
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R4
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R4
    gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_i) && $stable(out_q)));

    // R6
    freq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (quiet >= FB_STAGES && !out_valid) |=> $stable(freq_est));

    for (genvar g = 0; g < N; g++) begin : g_lane
        // R3
        lane_sym_chk: assert property (@(posedge clk) disable iff (rst)
            (out_i[g*DW +: DW] != MIN_CODE) && (out_q[g*DW +: DW] != MIN_CODE));
    end

endmodule

bind costas_par_top costas_par_chk #(
    .N         (N),
    .DW        (DW),
    .PH_W      (PH_W),
    .FB_STAGES (FB_STAGES)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q),
    .freq_est  (freq_est)
);

// File: tb/costas_par_top_tb_top.sv
module costas_par_top_tb_top;

    localparam int N         = 5;
    localparam int DW        = 12;
    localparam int AW        = 12;
    localparam int LUT_AW    = 6;
    localparam int PH_W      = 24;
    localparam int FB_STAGES = 3;
    localparam int KP        = 16;
    localparam int KI        = 1;

    localparam longint MASK = (longint'(1) << PH_W) - 1;
    localparam longint AMPL = (longint'(1) << (AW - 1)) - 1;
    localparam longint LIM  = (longint'(1) << (DW - 1)) - 1;
    localparam int     TABN = 1 << LUT_AW;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [N*DW-1:0] in_i = '0;
    logic [N*DW-1:0] in_q = '0;
    logic            out_valid;
    logic [N*DW-1:0] out_i;
    logic [N*DW-1:0] out_q;
    logic [PH_W-1:0] freq_est;

    always #5 clk = ~clk;

    costas_par_top #(
        .N (N), .DW (DW), .AW (AW), .LUT_AW (LUT_AW), .PH_W (PH_W),
        .FB_STAGES (FB_STAGES), .KP (KP), .KI (KI)
    ) dut_i (
        .clk (clk), .rst (rst), .in_valid (in_valid),
        .in_i (in_i), .in_q (in_q),
        .out_valid (out_valid), .out_i (out_i), .out_q (out_q),
        .freq_est (freq_est)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit sat_seen = 1'b0;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // ---------------- behavioural reference ----------------
    function automatic longint ref_sine(input longint i);
        longint hh, uu, d, m;
        hh = TABN / 2;
        uu = (i >= hh) ? i - hh : i;
        d  = 5 * hh * hh - 4 * uu * (hh - uu);
        m  = (AMPL * 16 * uu * (hh - uu) + d / 2) / d;
        return (i >= hh) ? -m : m;
    endfunction

    function automatic longint ref_round(input longint x);
        longint r;
        r = (x + (longint'(1) << (AW - 2))) >>> (AW - 1);
        if (r > LIM)  r = LIM;
        if (r < -LIM) r = -LIM;
        return r;
    endfunction

    function automatic longint sgn(input longint v);
        return (v < 0) ? -1 : 1;
    endfunction

    function automatic longint lane_of(input logic [N*DW-1:0] v, input int k);
        return longint'($signed(v[k*DW +: DW]));
    endfunction

    longint m_ph, m_fr;
    longint m_oi [N];
    longint m_oq [N];
    bit     m_ov;
    longint cyc;
    longint pend_at [$];
    longint pend_e  [$];

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_fr = 0; m_ov = 0; cyc = 0;
            for (int k = 0; k < N; k++) begin m_oi[k] = 0; m_oq[k] = 0; end
            pend_at.delete();
            pend_e.delete();
        end else begin
            bit     u;
            longint e_app, esum;
            cyc++;
            u = 0; e_app = 0;
            if (pend_at.size() > 0 && pend_at[0] == cyc) begin
                u = 1;
                e_app = pend_e.pop_front();
                void'(pend_at.pop_front());
            end
            if (in_valid) begin
                esum = 0;
                for (int k = 0; k < N; k++) begin
                    longint ph, ix, s, c, xi, xq, yi, yq;
                    ph = (m_ph + k * m_fr) & MASK;
                    ix = ph >> (PH_W - LUT_AW);
                    s  = ref_sine(ix);
                    c  = ref_sine((ix + TABN / 4) % TABN);
                    xi = lane_of(in_i, k);
                    xq = lane_of(in_q, k);
                    yi = ref_round(xi * c + xq * s);
                    yq = ref_round(xq * c - xi * s);
                    m_oi[k] = yi;
                    m_oq[k] = yq;
                    esum += sgn(yi) * yq - sgn(yq) * yi;
                end
                pend_at.push_back(cyc + 1 + FB_STAGES);
                pend_e.push_back(esum);
                m_ov = 1;
            end else begin
                m_ov = 0;
            end
            m_ph = (m_ph + (in_valid ? N * m_fr : 0) + (u ? KP * e_app : 0)) & MASK;
            m_fr = (m_fr + (u ? KI * e_app : 0)) & MASK;
        end
    end

    // Every-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(out_valid == m_ov, "R4 out_valid", longint'(out_valid), longint'(m_ov));
            for (int k = 0; k < N; k++) begin
                chk(lane_of(out_i, k) == m_oi[k], "R2 R3 R10 lane I", lane_of(out_i, k), m_oi[k]);
                chk(lane_of(out_q, k) == m_oq[k], "R2 R3 R10 lane Q", lane_of(out_q, k), m_oq[k]);
                if (lane_of(out_i, k) == LIM || lane_of(out_i, k) == -LIM ||
                    lane_of(out_q, k) == LIM || lane_of(out_q, k) == -LIM)
                    sat_seen = 1'b1;
            end
            chk(longint'(freq_est) == m_fr, "R5 R7 R8 R9 freq_est", longint'(freq_est), m_fr);
        end
    end

    // ---------------- stimulus ----------------
    real ang = 0.0;

    task automatic drive_block(input bit full);
        for (int k = 0; k < N; k++) begin
            real si, sq, ri, rq;
            if (full) begin
                si = 2047.0; sq = 2047.0;
            end else begin
                si = ($urandom_range(1) != 0) ? 700.0 : -700.0;
                sq = ($urandom_range(1) != 0) ? 700.0 : -700.0;
            end
            ri = si * $cos(ang) - sq * $sin(ang);
            rq = si * $sin(ang) + sq * $cos(ang);
            if (full) begin ri = si; rq = sq; end
            ang = ang + 0.003;
            in_i[k*DW +: DW] = DW'($rtoi(ri));
            in_q[k*DW +: DW] = DW'($rtoi(rq));
        end
        in_valid = 1'b1;
    endtask

    task automatic drive_gap();
        in_valid = 1'b0;
        in_i = {N{DW'($urandom)}};
        in_q = {N{DW'($urandom)}};
    endtask

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired before the run ended");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state visible at the ports
        chk(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
        chk(freq_est == '0, "R1 freq_est", longint'(freq_est), 0);
        chk(out_i == '0 && out_q == '0, "R1 outputs", longint'(out_i[DW-1:0]), 0);

        // One isolated block at zero phase: I=1000, Q=0 on every lane
        for (int k = 0; k < N; k++) begin
            in_i[k*DW +: DW] = DW'(1000);
            in_q[k*DW +: DW] = '0;
        end
        in_valid = 1'b1;
        @(negedge clk);
        drive_gap();
        // R2: zero phase gives cosine full scale, sine zero
        chk(lane_of(out_i, 0) == 1000, "R2 zero-phase I", lane_of(out_i, 0), 1000);
        chk(lane_of(out_q, N-1) == 0, "R2 zero-phase Q", lane_of(out_q, N-1), 0);
        chk(freq_est == '0, "R6 early freq", longint'(freq_est), 0);
        for (int j = 0; j < FB_STAGES; j++) begin
            @(negedge clk);
            chk(freq_est == '0, "R6 freq before arrival", longint'(freq_est), 0);
        end
        @(negedge clk);
        // R5 R6 R7: E = -1000 per lane, applied once
        chk(longint'(freq_est) == ((-1000 * N * KI) & MASK), "R6 R7 freq after arrival",
            longint'(freq_est), (-1000 * N * KI) & MASK);

        // Rotating stream with gaps and full-scale blocks
        for (int c = 0; c < 4000; c++) begin
            if (c == 2000) begin
                rst = 1'b1;
                drive_gap();
                @(negedge clk);
                @(negedge clk);
                rst = 1'b0;
                chk(freq_est == '0 && out_valid == 1'b0, "R1 mid-run reset",
                    longint'(freq_est), 0);
            end
            if ($urandom_range(3) != 0)
                drive_block((c % 47) == 13);
            else
                drive_gap();
            @(negedge clk);
        end
        drive_gap();
        repeat (FB_STAGES + 3) @(negedge clk);
        done = 1'b1;
        chk(sat_seen, "R3 saturation reached", longint'(sat_seen), 1);
        report();
    end

endmodule